// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Unit

This block lets two processor cores signal each other through small sets of pending flags ("doorbells"). Each core owns a bank of eight flags. A core can raise or withdraw flags in the bank of the other core. It can raise flags in its own bank. It can read its own bank and acknowledge entries in it.

Each core has its own register access port, and the two ports can be active in the same cycle. The meaning of a register address depends on which port issues the access. Two addresses act on the bank of the other core, and two act on the bank of the caller. Each bank drives one interrupt line toward its core, and that line is high while any flag in the bank is pending.

Both access ports are plain control interfaces. A request is taken in the cycle where its valid bit is high, with no back-pressure. Every read gives exactly one response, one cycle later.

Top module: `dbell_unit`

## Requirements
- R1: In reset and right after it, every flag in both banks is 0, both interrupt lines are low and both response-valid bits are low.
- R2: A write to address 0 from core c sets, in the bank of core 1-c, each flag whose write-data bit is 1.
- R3: A write to address 1 from core c clears, in the bank of core 1-c, each flag whose write-data bit is 1.
- R4: A write to address 2 from core c sets, in the bank of core c, each flag whose write-data bit is 1.
- R5: A write to address 3 from core c clears, in the bank of core c, each flag whose write-data bit is 1.
- R6: A read from core c at address 0 or 1 returns the bank of core 1-c. A read at address 2 or 3 returns the bank of core c. The value is the bank as it stood in the request cycle, in bits 7:0. It appears one cycle after the request, together with a one-cycle response-valid pulse, and the read leaves both banks unchanged.
- R7: A write-data bit of 0 leaves its flag unchanged, whatever the address.
- R8: When a flag is both set and cleared in the same cycle, by either or both ports, it ends up set.
- R9: The interrupt line of core c is the OR of the eight flags of its bank, taken through one register. It follows a change in the bank one cycle later.
- R10: Requests from both ports in the same cycle all take effect, and each port gets its own response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Request strobe, one bit per core |
| req_write | input | 2 | 1 = write, 0 = read, one bit per core |
| req_addr | input | 4 | Register address, 2 bits per core (core c at bits 2c+1:2c) |
| req_wdata | input | 16 | Write mask, 8 bits per core (core c at bits 8c+7:8c) |
| rsp_valid | output | 2 | Read response strobe, one bit per core |
| rsp_data | output | 16 | Read response data, 8 bits per core |
| irq | output | 2 | Doorbell interrupt, one bit per core |

## Verification
A write changes a bank at the clock edge that samples it. Because of this, a read issued in the next cycle already sees the new value, and that value shows on the response port one cycle after the read. The interrupt line trails the bank by one more register, so it moves two edges after the write. The bench holds a behavioural model of both banks and updates it at the same edges. It compares the interrupt lines, the response strobes and the response data at every falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned NCORE = 2;
  localparam int unsigned AW = 2;

  typedef enum logic [AW-1:0] {
    REG_PEER_SET = 2'd0,
    REG_PEER_CLR = 2'd1,
    REG_SELF_SET = 2'd2,
    REG_SELF_CLR = 2'd3
  } dbell_reg_e;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int unsigned BELLS = 8
) (
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BELLS-1:0] wdata_i,
  output logic [BELLS-1:0] peer_set_o,
  output logic [BELLS-1:0] peer_clr_o,
  output logic [BELLS-1:0] self_set_o,
  output logic [BELLS-1:0] self_clr_o
);
  logic wr_en;
  assign wr_en = valid_i && write_i;

  always_comb begin
    peer_set_o = '0;
    peer_clr_o = '0;
    self_set_o = '0;
    self_clr_o = '0;
    if (wr_en) begin
      unique case (dbell_reg_e'(addr_i))
        REG_PEER_SET: peer_set_o = wdata_i;
        REG_PEER_CLR: peer_clr_o = wdata_i;
        REG_SELF_SET: self_set_o = wdata_i;
        REG_SELF_CLR: self_clr_o = wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dbell_bank.sv
module dbell_bank #(
  parameter int unsigned BELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BELLS-1:0] set_i,
  input  logic [BELLS-1:0] clr_i,
  output logic [BELLS-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  // also covers R3 for the peer-clear path
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(flags_q));
endmodule

// File: rtl/dbell_readback.sv
module dbell_readback
  import dbell_pkg::*;
#(
  parameter int unsigned BELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BELLS-1:0] own_i,
  input  logic [BELLS-1:0] peer_i,
  output logic             rsp_valid_o,
  output logic [BELLS-1:0] rsp_data_o
);
  logic rd_en;
  assign rd_en = valid_i && !write_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rd_en;
      if (rd_en) rsp_data_o <= addr_i[AW-1] ? own_i : peer_i;
    end
  end

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !write_i) |=> rsp_valid_o);

  assert_no_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && !write_i) |=> !rsp_valid_o);
endmodule

// File: rtl/dbell_irq.sv
module dbell_irq #(
  parameter int unsigned BELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BELLS-1:0] flags_i,
  output logic             irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |flags_i;
  end

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_i) |=> irq_o);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flags_i) |=> !irq_o);
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
  import dbell_pkg::*;
#(
  parameter int unsigned BELLS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCORE-1:0]       req_valid,
  input  logic [NCORE-1:0]       req_write,
  input  logic [NCORE*AW-1:0]    req_addr,
  input  logic [NCORE*BELLS-1:0] req_wdata,
  output logic [NCORE-1:0]       rsp_valid,
  output logic [NCORE*BELLS-1:0] rsp_data,
  output logic [NCORE-1:0]       irq
);
  logic [BELLS-1:0] peer_set [NCORE];
  logic [BELLS-1:0] peer_clr [NCORE];
  logic [BELLS-1:0] self_set [NCORE];
  logic [BELLS-1:0] self_clr [NCORE];
  logic [BELLS-1:0] bank_q   [NCORE];

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    localparam int unsigned PEER = NCORE - 1 - c;

    dbell_decode #(.BELLS(BELLS)) u_dec (
      .valid_i    (req_valid[c]),
      .write_i    (req_write[c]),
      .addr_i     (req_addr[c*AW +: AW]),
      .wdata_i    (req_wdata[c*BELLS +: BELLS]),
      .peer_set_o (peer_set[c]),
      .peer_clr_o (peer_clr[c]),
      .self_set_o (self_set[c]),
      .self_clr_o (self_clr[c])
    );

    // bank c gathers its own self requests and the peer requests of the other core
    dbell_bank #(.BELLS(BELLS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (self_set[c] | peer_set[PEER]),
      .clr_i   (self_clr[c] | peer_clr[PEER]),
      .flags_q (bank_q[c])
    );

    dbell_readback #(.BELLS(BELLS)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_i     (req_valid[c]),
      .write_i     (req_write[c]),
      .addr_i      (req_addr[c*AW +: AW]),
      .own_i       (bank_q[c]),
      .peer_i      (bank_q[PEER]),
      .rsp_valid_o (rsp_valid[c]),
      .rsp_data_o  (rsp_data[c*BELLS +: BELLS])
    );

    dbell_irq #(.BELLS(BELLS)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (bank_q[c]),
      .irq_o   (irq[c])
    );
  end
endmodule

// File: tb/tb_dbell_unit.sv
module tb_dbell_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_valid = '0;
  logic [1:0]  req_write = '0;
  logic [3:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  rsp_valid;
  logic [15:0] rsp_data;
  logic [1:0]  irq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_unit #(.BELLS(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq(irq)
  );

  // behavioural reference model
  logic [7:0] m_bank [2];
  logic       m_irq  [2];
  logic       m_rv   [2];
  logic [7:0] m_rd   [2];

  always @(posedge clk or negedge rst_n) begin : model
    logic [7:0] s, k, w;
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        m_bank[t] <= '0; m_irq[t] <= 1'b0; m_rv[t] <= 1'b0; m_rd[t] <= '0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        s = '0; k = '0;
        for (int c = 0; c < 2; c++) begin
          w = req_wdata[c*8 +: 8];
          if (req_valid[c] && req_write[c]) begin
            case (req_addr[c*2 +: 2])
              2'd0: if (t != c) s = s | w;
              2'd1: if (t != c) k = k | w;
              2'd2: if (t == c) s = s | w;
              default: if (t == c) k = k | w;
            endcase
          end
        end
        m_irq[t]  <= |m_bank[t];
        m_bank[t] <= (m_bank[t] & ~k) | s;
        m_rv[t]   <= req_valid[t] && !req_write[t];
        if (req_valid[t] && !req_write[t])
          m_rd[t] <= req_addr[t*2+1] ? m_bank[t] : m_bank[1-t];
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int c = 0; c < 2; c++) begin
      check("R9", $sformatf("irq[%0d] during %s", c, tag), int'(irq[c]), int'(m_irq[c]));
      check(tag, $sformatf("rsp_valid[%0d]", c), int'(rsp_valid[c]), int'(m_rv[c]));
      if (m_rv[c]) check(tag, $sformatf("rsp_data[%0d]", c), int'(rsp_data[c*8 +: 8]), int'(m_rd[c]));
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic put(input int c, input bit wr, input logic [1:0] a, input logic [7:0] d);
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_addr[c*2 +: 2] = a;
    req_wdata[c*8 +: 8] = d;
  endtask

  task automatic op(input string tag, input int c, input bit wr, input logic [1:0] a, input logic [7:0] d);
    put(c, wr, a, d);
    cyc(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    @(negedge clk);
    check("R1", "irq in reset", int'(irq), 0);
    check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 2);
    op("R1", 0, 0, 2'd3, 8'h00);
    op("R1", 1, 0, 2'd0, 8'h00);
    idle("R1", 1);

    // R2: core 0 posts to core 1
    op("R2", 0, 1, 2'd0, 8'hA5);
    op("R2", 1, 0, 2'd3, 8'h00);
    op("R2", 0, 0, 2'd1, 8'h00);
    idle("R2", 2);
    // R7: zero mask changes nothing
    op("R7", 0, 1, 2'd1, 8'h00);
    op("R7", 1, 1, 2'd3, 8'h00);
    op("R7", 1, 0, 2'd2, 8'h00);
    // R3: core 0 withdraws part of what it posted
    op("R3", 0, 1, 2'd1, 8'h05);
    op("R3", 1, 0, 2'd2, 8'h00);
    // R4: core 1 rings itself, core 0 rings itself
    op("R4", 1, 1, 2'd2, 8'h40);
    op("R4", 0, 1, 2'd2, 8'h81);
    op("R4", 0, 0, 2'd3, 8'h00);
    op("R4", 1, 0, 2'd1, 8'h00);
    idle("R4", 2);
    // R5: acknowledge own bells
    op("R5", 1, 1, 2'd3, 8'hE0);
    op("R5", 1, 0, 2'd3, 8'h00);
    op("R5", 0, 1, 2'd3, 8'h81);
    idle("R5", 2);
    op("R5", 0, 0, 2'd2, 8'h00);
    // R2 reverse direction: core 1 posts to core 0
    op("R2", 1, 1, 2'd0, 8'h3C);
    op("R2", 0, 0, 2'd3, 8'h00);
    // R8: set and clear on the same flags in one cycle
    put(0, 1, 2'd0, 8'h0F);
    put(1, 1, 2'd3, 8'hFF);
    cyc("R8");
    op("R8", 1, 0, 2'd3, 8'h00);
    put(0, 1, 2'd3, 8'h30);
    put(1, 1, 2'd0, 8'h10);
    cyc("R8");
    op("R8", 0, 0, 2'd2, 8'h00);
    put(0, 1, 2'd2, 8'h02);
    put(0, 1, 2'd2, 8'h02);
    cyc("R8");
    // R10: both ports at once
    put(0, 1, 2'd2, 8'h11);
    put(1, 1, 2'd2, 8'h22);
    cyc("R10");
    put(0, 0, 2'd1, 8'h00);
    put(1, 0, 2'd2, 8'h00);
    cyc("R10");
    put(0, 0, 2'd2, 8'h00);
    put(1, 0, 2'd0, 8'h00);
    cyc("R10");
    // R6: back-to-back reads at every address, then clear all
    for (int a = 0; a < 4; a++) begin
      put(0, 0, 2'(a), 8'h00);
      put(1, 0, 2'(3 - a), 8'h00);
      cyc("R6");
    end
    put(0, 1, 2'd3, 8'hFF);
    put(1, 1, 2'd3, 8'hFF);
    cyc("R9");
    idle("R9", 3);
    op("R9", 0, 0, 2'd0, 8'h00);
    idle("R9", 1);
    finish_run();
  end
endmodule